// File: doc/BRIEF.md
# Machine-Check Error Register Bank

This block holds the state of one error-reporting bank of a machine-check unit, together with a small, configurable set of extended state-capture registers. A capture pulse from the error-detection logic writes the error status word, the faulting address and optional extra information into the bank. In the same edge it takes a snapshot of the general-purpose register values that the core presents.

Software reaches the bank through a single-cycle model-specific-register style port. That port carries a strobe, a write flag, an address, 64-bit write data, combinational read data and a fault output. The block enforces the access rules. The capability word is read-only. The data registers accept only an all-zero clearing write. The extra-information register can be left out when the bank is built. Any illegal access raises the fault output and changes no state.

Addresses: capability 0x100, status 0x101, error address 0x102, extra information 0x103. Extended state slot k sits at 0x180 + k. Slot 0 holds the first general-purpose value and slot 1 holds the second.

Top module: `mce_err_bank`

## Requirements
- R1: After reset the status, address, extra-information and extended state registers all read zero without fault.
- R2: On a cycle with `cap_valid` high, the status, address, extra information and every extended slot take their new values at the same clock edge. Slot k (address 0x180 + k) takes `cap_gpr[k]`.
- R3: Status bit 59 is the extra-information-valid flag. A capture sets it to `cap_misc_vld`, whatever the value of `cap_status[59]`. Reading the extra-information register returns zero while this flag is clear.
- R4: With `ADDR_BITS` = 36, the address register keeps `cap_addr[35:0]`, and bits 63:36 read as zero.
- R5: A write of all zeros to status, address, extra information (when present) or an implemented extended slot clears that register and raises no fault.
- R6: A write with any bit set to one of those registers raises the fault output and leaves the register unchanged.
- R7: When `MISC_IMPL` is 0, every read or write of 0x103 faults and changes nothing. Status bit 59 then stays clear after a capture.
- R8: The capability word at 0x100 reads bit 9 as the extended-state presence flag and bits 7:0 as the number of extended slots. Both fields read zero when extended state is absent. Any write to it faults.
- R9: Access to an extended slot at or beyond the implemented count faults. When extended state is absent, any access in the extended range faults. Any access to an address that decodes to no register also faults.
- R10: `acc_fault` is combinational and is high only in a cycle with `acc_en` high. `acc_rdata` is zero on a faulting access, on a write, and in an idle cycle.
- R11: When a capture and a clearing write land in the same cycle, the captured values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Register address |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data (combinational) |
| acc_fault | output | 1 | Protection fault for the current access |
| cap_valid | input | 1 | Error-capture pulse |
| cap_status | input | 64 | Status word to capture |
| cap_addr | input | 64 | Faulting address to capture |
| cap_misc | input | 64 | Extra error information |
| cap_misc_vld | input | 1 | Extra information accompanies this capture |
| cap_gpr | input | 64×EXT_CNT | General-purpose register values to snapshot |

## Verification
The assertions assume that `cap_valid`, `cap_misc_vld` and the access inputs are driven to known values from reset onward. They also assume each access lasts exactly one cycle, so that the state of the next cycle can be attributed to that access alone. The stimulus changes every input only on the falling edge and holds the strobe for a single cycle. It keeps `cap_valid` low except on deliberate capture cycles, one of which overlaps a clearing write on purpose. A second instance, built without the extra-information register and without extended state, shares the same inputs so that the faulting paths of that build are exercised.

// File: rtl/mce_pkg.sv
package mce_pkg;
    localparam int DW         = 64;
    localparam int ADR_CAP    = 'h100;
    localparam int ADR_STAT   = 'h101;
    localparam int ADR_ADDR   = 'h102;
    localparam int ADR_MISC   = 'h103;
    localparam int ADR_EXT    = 'h180;
    localparam int MISCV_BIT  = 59;
    localparam int CAP_PRES_B = 9;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CAP,
        TGT_STAT,
        TGT_ADDR,
        TGT_MISC,
        TGT_EXT
    } tgt_e;
endpackage

// File: rtl/mce_acc_decode.sv
module mce_acc_decode
    import mce_pkg::*;
#(
    parameter int AW          = 12,
    parameter bit MISC_IMPL   = 1'b1,
    parameter bit EXT_PRESENT = 1'b1,
    parameter int EXT_CNT     = 2,
    parameter int IDX_W       = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [AW-1:0]    acc_addr,
    input  logic [DW-1:0]    acc_wdata,
    output tgt_e             tgt,
    output logic [IDX_W-1:0] ext_idx,
    output logic             clr,
    output logic             fault
);
    localparam logic [AW-1:0] A_CAP  = AW'(ADR_CAP);
    localparam logic [AW-1:0] A_STAT = AW'(ADR_STAT);
    localparam logic [AW-1:0] A_ADDR = AW'(ADR_ADDR);
    localparam logic [AW-1:0] A_MISC = AW'(ADR_MISC);
    localparam logic [AW-1:0] A_EXT  = AW'(ADR_EXT);
    localparam logic [AW-1:0] N_EXT  = AW'(EXT_CNT);

    logic [AW-1:0] ext_off;
    logic          zero_ok;
    logic          legal;

    always_comb begin
        ext_off = acc_addr - A_EXT;
        ext_idx = ext_off[IDX_W-1:0];
        zero_ok = !acc_wr || (acc_wdata == '0);
        tgt     = TGT_NONE;
        legal   = 1'b0;
        if (acc_addr == A_CAP) begin
            tgt   = TGT_CAP;
            legal = !acc_wr;
        end else if (acc_addr == A_STAT) begin
            tgt   = TGT_STAT;
            legal = zero_ok;
        end else if (acc_addr == A_ADDR) begin
            tgt   = TGT_ADDR;
            legal = zero_ok;
        end else if (acc_addr == A_MISC) begin
            tgt   = TGT_MISC;
            legal = MISC_IMPL && zero_ok;
        end else if (EXT_PRESENT && (acc_addr >= A_EXT) && (ext_off < N_EXT)) begin
            tgt   = TGT_EXT;
            legal = zero_ok;
        end
        fault = acc_en && !legal;
        clr   = acc_en && legal && acc_wr;
    end

    // R6: a clearing write and a fault never coexist
    p_clr_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && fault));

    // R7: absent extra-information register always faults
    p_nomisc_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (acc_addr == A_MISC) && !MISC_IMPL) |-> fault);
endmodule

// File: rtl/mce_state.sv
module mce_state
    import mce_pkg::*;
#(
    parameter int EXT_CNT   = 2,
    parameter int ADDR_BITS = 36,
    parameter bit MISC_IMPL = 1'b1,
    parameter int IDX_W     = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_valid,
    input  logic [DW-1:0]               cap_status,
    input  logic [DW-1:0]               cap_addr,
    input  logic [DW-1:0]               cap_misc,
    input  logic                        cap_misc_vld,
    input  logic [EXT_CNT-1:0][DW-1:0]  cap_gpr,
    input  logic                        clr,
    input  tgt_e                        tgt,
    input  logic [IDX_W-1:0]            ext_idx,
    output logic [DW-1:0]               stat_q,
    output logic [DW-1:0]               addr_q,
    output logic [DW-1:0]               misc_q,
    output logic [EXT_CNT-1:0][DW-1:0]  ext_q
);
    localparam logic [DW-1:0] ADDR_KEEP =
        (ADDR_BITS >= DW) ? {DW{1'b1}} : ((64'd1 << ADDR_BITS) - 64'd1);

    typedef struct packed {
        logic [DW-1:0]              stat;
        logic [DW-1:0]              addr;
        logic [DW-1:0]              misc;
        logic [EXT_CNT-1:0][DW-1:0] ext;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr) begin
            unique case (tgt)
                TGT_STAT: bank_d.stat = '0;
                TGT_ADDR: bank_d.addr = '0;
                TGT_MISC: bank_d.misc = '0;
                TGT_EXT:  bank_d.ext[ext_idx] = '0;
                default:  ;
            endcase
        end
        if (cap_valid) begin
            bank_d.stat            = cap_status;
            bank_d.stat[MISCV_BIT] = MISC_IMPL && cap_misc_vld;
            bank_d.addr            = cap_addr & ADDR_KEEP;
            if (MISC_IMPL && cap_misc_vld) begin
                bank_d.misc = cap_misc;
            end
            bank_d.ext = cap_gpr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_q = bank_q.stat;
    assign addr_q = bank_q.addr;
    assign misc_q = bank_q.misc;
    assign ext_q  = bank_q.ext;

    // R2: snapshot of the first general-purpose value lands with the capture
    p_ext_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> (ext_q[0] == $past(cap_gpr[0])));

    // R3: flag follows the accompanying-data input
    p_miscv_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> (stat_q[MISCV_BIT] == $past(cap_misc_vld && MISC_IMPL)));

    // R4: reserved address bits never hold ones
    p_addr_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_q & ~ADDR_KEEP) == '0));

    // R6: without capture or legal clear the bank holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_valid && !clr) |=> ($stable(stat_q) && $stable(addr_q)
                                  && $stable(misc_q) && $stable(ext_q)));
endmodule

// File: rtl/mce_err_bank.sv
module mce_err_bank
    import mce_pkg::*;
#(
    parameter int AW          = 12,
    parameter int ADDR_BITS   = 36,
    parameter bit MISC_IMPL   = 1'b1,
    parameter bit EXT_PRESENT = 1'b1,
    parameter int EXT_CNT     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_en,
    input  logic                       acc_wr,
    input  logic [AW-1:0]              acc_addr,
    input  logic [DW-1:0]              acc_wdata,
    output logic [DW-1:0]              acc_rdata,
    output logic                       acc_fault,
    input  logic                       cap_valid,
    input  logic [DW-1:0]              cap_status,
    input  logic [DW-1:0]              cap_addr,
    input  logic [DW-1:0]              cap_misc,
    input  logic                       cap_misc_vld,
    input  logic [EXT_CNT-1:0][DW-1:0] cap_gpr
);
    localparam int IDX_W = (EXT_CNT > 1) ? $clog2(EXT_CNT) : 1;

    tgt_e                       tgt;
    logic [IDX_W-1:0]           ext_idx;
    logic                       clr;
    logic [DW-1:0]              stat_q, addr_q, misc_q;
    logic [EXT_CNT-1:0][DW-1:0] ext_q;
    logic [DW-1:0]              cap_word;

    generate
        if (EXT_PRESENT) begin : g_cap_ext
            assign cap_word = DW'((64'd1 << CAP_PRES_B) | 64'(EXT_CNT & 'hFF));
        end else begin : g_cap_none
            assign cap_word = '0;
        end
    endgenerate

    mce_acc_decode #(
        .AW(AW), .MISC_IMPL(MISC_IMPL), .EXT_PRESENT(EXT_PRESENT),
        .EXT_CNT(EXT_CNT), .IDX_W(IDX_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .tgt(tgt), .ext_idx(ext_idx), .clr(clr), .fault(acc_fault)
    );

    mce_state #(
        .EXT_CNT(EXT_CNT), .ADDR_BITS(ADDR_BITS),
        .MISC_IMPL(MISC_IMPL), .IDX_W(IDX_W)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid),
        .cap_status(cap_status), .cap_addr(cap_addr), .cap_misc(cap_misc),
        .cap_misc_vld(cap_misc_vld), .cap_gpr(cap_gpr), .clr(clr),
        .tgt(tgt), .ext_idx(ext_idx),
        .stat_q(stat_q), .addr_q(addr_q), .misc_q(misc_q), .ext_q(ext_q)
    );

    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_wr && !acc_fault) begin
            unique case (tgt)
                TGT_CAP:  acc_rdata = cap_word;
                TGT_STAT: acc_rdata = stat_q;
                TGT_ADDR: acc_rdata = addr_q;
                TGT_MISC: acc_rdata = stat_q[MISCV_BIT] ? misc_q : '0;
                TGT_EXT:  acc_rdata = ext_q[ext_idx];
                default:  acc_rdata = '0;
            endcase
        end
    end

    // R10: fault only accompanies a strobe
    p_fault_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> acc_en);

    // R10: faulting access returns no data
    p_fault_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (acc_rdata == '0));
endmodule

// File: tb/mce_err_bank_tb.sv
module mce_err_bank_tb_top;
    localparam int PERIOD = 10;
    localparam int NV     = 22;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [63:0] wdata;
        logic [63:0] exp;
        logic        ef;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] ST_A = 64'h0800_00AB_0000_1234;
    localparam logic [63:0] AD_A = 64'h0000_0001_2345_6789;
    localparam logic [63:0] MS_A = 64'hDEAD_BEEF_0000_0001;
    localparam logic [63:0] G0_A = 64'h1111_1111_1111_1111;
    localparam logic [63:0] G1_A = 64'h2222_2222_2222_2222;

    // rows after capture A: each row names its requirement in the trailing comment
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h100, 64'h0, 64'h202, 1'b0, 4'd8},  // R8 capability word
        '{1'b0, 12'h101, 64'h0, ST_A,    1'b0, 4'd2},  // R2 status
        '{1'b0, 12'h102, 64'h0, AD_A,    1'b0, 4'd4},  // R4 address masked
        '{1'b0, 12'h103, 64'h0, MS_A,    1'b0, 4'd3},  // R3 flag set, data visible
        '{1'b0, 12'h180, 64'h0, G0_A,    1'b0, 4'd2},  // R2 slot 0
        '{1'b0, 12'h181, 64'h0, G1_A,    1'b0, 4'd2},  // R2 slot 1
        '{1'b0, 12'h182, 64'h0, 64'h0,   1'b1, 4'd9},  // R9 beyond count
        '{1'b0, 12'h0FF, 64'h0, 64'h0,   1'b1, 4'd9},  // R9 unmapped
        '{1'b1, 12'h100, 64'h0, 64'h0,   1'b1, 4'd8},  // R8 cap write
        '{1'b1, 12'h103, 64'h1, 64'h0,   1'b1, 4'd6},  // R6 nonzero write
        '{1'b0, 12'h103, 64'h0, MS_A,    1'b0, 4'd6},  // R6 unchanged
        '{1'b1, 12'h101, 64'h8, 64'h0,   1'b1, 4'd6},  // R6 nonzero write
        '{1'b0, 12'h101, 64'h0, ST_A,    1'b0, 4'd6},  // R6 unchanged
        '{1'b1, 12'h180, 64'h0, 64'h0,   1'b0, 4'd5},  // R5 clear slot 0
        '{1'b0, 12'h180, 64'h0, 64'h0,   1'b0, 4'd5},  // R5 cleared
        '{1'b0, 12'h181, 64'h0, G1_A,    1'b0, 4'd5},  // R5 other slot kept
        '{1'b1, 12'h102, 64'h0, 64'h0,   1'b0, 4'd5},  // R5 clear address
        '{1'b0, 12'h102, 64'h0, 64'h0,   1'b0, 4'd5},  // R5 cleared
        '{1'b1, 12'h103, 64'h0, 64'h0,   1'b0, 4'd5},  // R5 clear extra info
        '{1'b0, 12'h103, 64'h0, 64'h0,   1'b0, 4'd5},  // R5 cleared
        '{1'b1, 12'h101, 64'h0, 64'h0,   1'b0, 4'd5},  // R5 clear status
        '{1'b0, 12'h101, 64'h0, 64'h0,   1'b0, 4'd5}   // R5 cleared
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_en = 1'b0, acc_wr = 1'b0;
    logic [11:0]      acc_addr = '0;
    logic [63:0]      acc_wdata = '0;
    logic [63:0]      rdata1, rdata2;
    logic             fault1, fault2;
    logic             cap_valid = 1'b0, cap_misc_vld = 1'b0;
    logic [63:0]      cap_status = '0, cap_addr = '0, cap_misc = '0;
    logic [1:0][63:0] cap_gpr = '0;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    mce_err_bank dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(rdata1),
        .acc_fault(fault1), .cap_valid(cap_valid), .cap_status(cap_status),
        .cap_addr(cap_addr), .cap_misc(cap_misc), .cap_misc_vld(cap_misc_vld),
        .cap_gpr(cap_gpr)
    );

    mce_err_bank #(.MISC_IMPL(1'b0), .EXT_PRESENT(1'b0)) dut_lite_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(rdata2),
        .acc_fault(fault2), .cap_valid(cap_valid), .cap_status(cap_status),
        .cap_addr(cap_addr), .cap_misc(cap_misc), .cap_misc_vld(cap_misc_vld),
        .cap_gpr(cap_gpr)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // starts on a falling edge, samples before the rising edge, returns on a falling edge
    task automatic acc(input logic wr, input logic [11:0] a, input logic [63:0] wd,
                       output logic [63:0] r1, output logic f1,
                       output logic [63:0] r2, output logic f2);
        acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = wd;
        #2;
        r1 = rdata1; f1 = fault1; r2 = rdata2; f2 = fault2;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
    endtask

    task automatic capture(input logic [63:0] st, input logic [63:0] ad,
                           input logic [63:0] ms, input logic mv,
                           input logic [63:0] g0, input logic [63:0] g1);
        cap_valid = 1'b1; cap_status = st; cap_addr = ad; cap_misc = ms;
        cap_misc_vld = mv; cap_gpr[0] = g0; cap_gpr[1] = g1;
        @(posedge clk);
        @(negedge clk);
        cap_valid = 1'b0; cap_misc_vld = 1'b0;
    endtask

    initial begin
        #(PERIOD * 5000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] r1, r2;
        logic        f1, f2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        acc(1'b0, 12'h101, '0, r1, f1, r2, f2); chk("R1 status", {r1[63:1], f1}, '0);
        acc(1'b0, 12'h102, '0, r1, f1, r2, f2); chk("R1 address", {r1[63:1], f1}, '0);
        acc(1'b0, 12'h103, '0, r1, f1, r2, f2); chk("R1 extra", {r1[63:1], f1}, '0);
        acc(1'b0, 12'h181, '0, r1, f1, r2, f2); chk("R1 slot1", {r1[63:1], f1}, '0);
        chk("R1 slot1 low bit", {63'd0, r1[0]}, '0);

        // capture A: status input has flag bit clear, address has junk above bit 35
        capture(64'h0000_00AB_0000_1234, 64'hFFFF_FFF1_2345_6789, MS_A, 1'b1, G0_A, G1_A);

        for (int i = 0; i < NV; i++) begin
            acc(VECS[i].wr, VECS[i].addr, VECS[i].wdata, r1, f1, r2, f2);
            checks++;
            if (r1 !== VECS[i].exp || f1 !== VECS[i].ef) begin
                errors++;
                $display("FAIL R%0d vector %0d got=%h/%b exp=%h/%b",
                         VECS[i].req, i, r1, f1, VECS[i].exp, VECS[i].ef);
            end
        end

        // R10 fault drops with the strobe; idle read data is zero
        acc(1'b0, 12'h0FF, '0, r1, f1, r2, f2);
        chk("R10 fault on bad access", {63'd0, f1}, 64'd1);
        #2;
        chk("R10 no fault when idle", {63'd0, fault1}, '0);
        chk("R10 idle read data", rdata1, '0);
        @(negedge clk);

        // R3 capture without extra info: flag cleared even if input bit 59 set
        capture(64'h0800_0000_0000_0005, 64'h10, 64'h55, 1'b0, 64'h7, 64'h8);
        acc(1'b0, 12'h101, '0, r1, f1, r2, f2); chk("R3 status flag forced clear", r1, 64'h5);
        acc(1'b0, 12'h103, '0, r1, f1, r2, f2); chk("R3 extra reads zero", r1, '0);

        // R11 capture collides with a clearing write of status
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 12'h101; acc_wdata = '0;
        capture(64'h0000_0000_0000_0099, 64'h20, 64'h66, 1'b1, 64'h9, 64'hA);
        acc_en = 1'b0; acc_wr = 1'b0;
        acc(1'b0, 12'h101, '0, r1, f1, r2, f2);
        chk("R11 capture wins", r1, 64'h0800_0000_0000_0099);

        // R7 / R8 / R9 on the build without extra info and without extended state
        acc(1'b0, 12'h101, '0, r1, f1, r2, f2);
        chk("R7 flag stays clear", r2, 64'h0000_0000_0000_0099);
        acc(1'b0, 12'h103, '0, r1, f1, r2, f2);
        chk("R7 read faults", {r2[62:0], f2}, 64'd1);
        acc(1'b1, 12'h103, '0, r1, f1, r2, f2);
        chk("R7 zero write faults", {63'd0, f2}, 64'd1);
        acc(1'b0, 12'h101, '0, r1, f1, r2, f2);
        chk("R7 state unchanged", r2, 64'h0000_0000_0000_0099);
        acc(1'b0, 12'h100, '0, r1, f1, r2, f2);
        chk("R8 capability absent", {r2[62:0], f2}, '0);
        acc(1'b0, 12'h180, '0, r1, f1, r2, f2);
        chk("R9 ext absent faults", {r2[62:0], f2}, 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule